// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block sits beside a CPU core and watches the 16-bit address bus. It raises a break when the program counter reaches a programmed address, or when software forces one. The compare is done by two 8-bit comparators, one per address byte. Only bus cycles that the core marks as program-counter fetches can trigger it.

A break does not stop the core at once. It stays pending until the core signals an instruction boundary. At that boundary the block asks the core to put a software-interrupt opcode into its instruction register. It also supplies the vector address, which is `VEC_NORMAL` in normal mode and `VEC_MONITOR` when monitor mode is selected. A status output stays high for the whole break routine, so that neighbouring modules can hold their flags. A completed return-from-interrupt ends the break.

Software sees four byte registers through a simple write/read port:

| Select | Register |
|--------|----------|
| 0 | Control/status: bit 0 = arm, bit 1 = active, bits 7:2 read 0 |
| 1 | Break address, high byte |
| 2 | Break address, low byte |
| 3 | Reads 0 |

Top module: `addr_break_unit`

## Requirements
- R1: After reset, every register reads 0x00 and both `break_busy` and `swi_inject` are low.
- R2: A write with `reg_sel`=1 sets the high address byte and `reg_sel`=2 sets the low byte. With `reg_sel`=0, bit 0 is arm and bit 1 is active, and bits 7:2 read 0. `reg_sel`=3 reads 0x00. Reads are combinational on `reg_rdata`.
- R3: With arm=1, a cycle with `pc_fetch`=1 makes a break pending when `cpu_addr[15:8]` equals the high byte and `cpu_addr[7:0]` equals the low byte. A mismatch in either byte, or `pc_fetch`=0, does nothing.
- R4: With arm=0, an address match never makes a break pending.
- R5: Writing select 0 with bit 1 = 1 makes a break pending whatever the value of arm.
- R6: `swi_inject` is high only in a cycle where a break is pending and `instr_done` is high. It lasts exactly that cycle.
- R7: `vec_addr` is 0xFFFC when `monitor_mode`=0 and 0xFEFC when `monitor_mode`=1.
- R8: `break_busy` goes high on the clock edge that ends the `swi_inject` cycle. It stays high until the edge where `rti_done` is seen high.
- R9: The active bit reads 1 while a break is pending or busy, and 0 once the break ends. Writing select 0 with bit 1 = 0 cancels a pending break or ends a busy one.
- R10: An address match while `break_busy` is high has no effect: after `rti_done`, the active bit reads 0 and no new break starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| cpu_addr | input | 16 | CPU address bus |
| pc_fetch | input | 1 | Current bus cycle is a program-counter fetch |
| instr_done | input | 1 | Current instruction completes this cycle |
| rti_done | input | 1 | Return-from-interrupt completes this cycle |
| monitor_mode | input | 1 | Selects the monitor-mode vector |
| swi_inject | output | 1 | Substitute a software-interrupt opcode |
| vec_addr | output | 16 | Address of the high byte of the break vector |
| break_busy | output | 1 | Break routine in progress |

## Verification
The break state can be read back through the active bit in the same cycle, so a wrong state shows at the register port one edge after the event that caused it. A pending state that is missing or left over shows as an absent or extra `swi_inject` at the next `instr_done`. A busy state that is wrong shows on `break_busy` one edge after the inject or the return. The bench sweeps every value of each address byte while the other byte matches, so any fault in one comparator shows up in that sweep.

// File: rtl/addr_break_unit.sv
module addr_break_unit #(
  parameter logic [15:0] VEC_NORMAL  = 16'hFFFC,
  parameter logic [15:0] VEC_MONITOR = 16'hFEFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] cpu_addr,
  input  logic        pc_fetch,
  input  logic        instr_done,
  input  logic        rti_done,
  input  logic        monitor_mode,
  output logic        swi_inject,
  output logic [15:0] vec_addr,
  output logic        break_busy
);
  localparam int BYTE_W  = 8;
  localparam int ARM_BIT = 0;
  localparam int ACT_BIT = 1;

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_BRK} st_t;

  st_t              st;
  logic             arm;
  logic [BYTE_W-1:0] bp_hi, bp_lo;

  logic ctrl_wr, sw_set, sw_clr, hi_hit, lo_hit, addr_hit;

  assign ctrl_wr  = reg_wr && (reg_sel == 2'd0);
  assign sw_set   = ctrl_wr &&  reg_wdata[ACT_BIT];
  assign sw_clr   = ctrl_wr && !reg_wdata[ACT_BIT];
  assign hi_hit   = (cpu_addr[2*BYTE_W-1:BYTE_W] == bp_hi);
  assign lo_hit   = (cpu_addr[BYTE_W-1:0] == bp_lo);
  assign addr_hit = arm && pc_fetch && hi_hit && lo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm   <= 1'b0;
      bp_hi <= '0;
      bp_lo <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0:    arm   <= reg_wdata[ARM_BIT];
        2'd1:    bp_hi <= reg_wdata;
        2'd2:    bp_lo <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE: if (sw_set || addr_hit) st <= S_PEND;
        S_PEND: if (sw_clr) st <= S_IDLE;
                else if (instr_done) st <= S_BRK;
        S_BRK:  if (sw_clr || rti_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign swi_inject = (st == S_PEND) && instr_done && !sw_clr;
  assign break_busy = (st == S_BRK);
  assign vec_addr   = monitor_mode ? VEC_MONITOR : VEC_NORMAL;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {6'b0, st != S_IDLE, arm};
      2'd1:    reg_rdata = bp_hi;
      2'd2:    reg_rdata = bp_lo;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module addr_break_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_sel,
  input logic        reg_wr,
  input logic [7:0]  reg_rdata,
  input logic        instr_done,
  input logic        rti_done,
  input logic        swi_inject,
  input logic        break_busy
);
  assert_inject_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swi_inject |-> instr_done);

  assert_inject_then_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swi_inject |=> break_busy);

  assert_busy_rise_needs_inject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !break_busy ##1 break_busy |-> $past(swi_inject));

  assert_rti_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (break_busy && rti_done) |=> !break_busy);

  assert_no_inject_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    break_busy |-> !swi_inject);

  assert_active_reads_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (break_busy && reg_sel == 2'd0) |-> reg_rdata[1]);
endmodule

bind addr_break_unit addr_break_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .instr_done(instr_done), .rti_done(rti_done),
  .swi_inject(swi_inject), .break_busy(break_busy)
);

// File: tb/tb_addr_break_unit.sv
module tb_addr_break_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr;
  logic        pc_fetch, instr_done, rti_done, monitor_mode;
  logic        swi_inject, break_busy;
  logic [15:0] vec_addr;

  int total = 0;
  int fails = 0;

  addr_break_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .pc_fetch(pc_fetch), .instr_done(instr_done), .rti_done(rti_done),
    .monitor_mode(monitor_mode), .swi_inject(swi_inject),
    .vec_addr(vec_addr), .break_busy(break_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [7:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic fetch(input logic [15:0] a, input logic q);
    cpu_addr = a; pc_fetch = q;
    step();
    pc_fetch = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog R6: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    cpu_addr = 16'h0000; pc_fetch = 1'b0; instr_done = 1'b0;
    rti_done = 1'b0; monitor_mode = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int s = 0; s < 4; s++) rd("R1 reg after reset", 2'(s), 8'h00);
    chk("R1 busy", {15'd0, break_busy}, 16'd0);
    chk("R1 inject", {15'd0, swi_inject}, 16'd0);

    // R2 register access
    wr(2'd1, 8'h12); wr(2'd2, 8'h34);
    rd("R2 high byte", 2'd1, 8'h12);
    rd("R2 low byte", 2'd2, 8'h34);
    wr(2'd0, 8'hFD);
    rd("R2 ctrl bits 7:2 read 0", 2'd0, 8'h01);
    wr(2'd3, 8'hAA);
    rd("R2 select 3 reads 0", 2'd3, 8'h00);

    // R4 unarmed match ignored
    wr(2'd0, 8'h00);
    fetch(16'h1234, 1'b1);
    rd("R4 no pending when unarmed", 2'd0, 8'h00);
    instr_done = 1'b1; #1;
    chk("R4 no inject when unarmed", {15'd0, swi_inject}, 16'd0);
    step(); instr_done = 1'b0;
    chk("R4 no busy when unarmed", {15'd0, break_busy}, 16'd0);

    // R3 sweep low byte, then high byte
    wr(2'd0, 8'h01);
    for (int v = 0; v < 256; v++) begin
      fetch({8'h12, 8'(v)}, 1'b1);
      rd("R3 low byte sweep", 2'd0, (v == 'h34) ? 8'h03 : 8'h01);
      wr(2'd0, 8'h01);
    end
    for (int v = 0; v < 256; v++) begin
      fetch({8'(v), 8'h34}, 1'b1);
      rd("R3 high byte sweep", 2'd0, (v == 'h12) ? 8'h03 : 8'h01);
      wr(2'd0, 8'h01);
    end
    fetch(16'h1234, 1'b0);
    rd("R3 no match without pc_fetch", 2'd0, 8'h01);

    // R6 deferral to instruction boundary
    fetch(16'h1234, 1'b1);
    rd("R9 active while pending", 2'd0, 8'h03);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 no inject before boundary", {15'd0, swi_inject}, 16'd0);
      chk("R6 not busy before boundary", {15'd0, break_busy}, 16'd0);
    end
    monitor_mode = 1'b0;
    instr_done = 1'b1; #1;
    chk("R6 inject at boundary", {15'd0, swi_inject}, 16'd1);
    chk("R7 normal vector", vec_addr, 16'hFFFC);
    step(); instr_done = 1'b0;
    chk("R8 busy after inject", {15'd0, break_busy}, 16'd1);
    chk("R6 inject lasts one cycle", {15'd0, swi_inject}, 16'd0);

    // R10 match during busy ignored
    fetch(16'h1234, 1'b1);
    instr_done = 1'b1; #1;
    chk("R10 no inject while busy", {15'd0, swi_inject}, 16'd0);
    step(); instr_done = 1'b0;
    rti_done = 1'b1; step(); rti_done = 1'b0;
    chk("R8 busy ends on rti", {15'd0, break_busy}, 16'd0);
    rd("R10 active clear after rti", 2'd0, 8'h01);
    instr_done = 1'b1; #1;
    chk("R10 no retrigger", {15'd0, swi_inject}, 16'd0);
    step(); instr_done = 1'b0;

    // R5 software-forced break while unarmed
    wr(2'd0, 8'h02);
    rd("R5 forced pending", 2'd0, 8'h02);
    monitor_mode = 1'b1;
    instr_done = 1'b1; #1;
    chk("R5 forced inject", {15'd0, swi_inject}, 16'd1);
    chk("R7 monitor vector", vec_addr, 16'hFEFC);
    step(); instr_done = 1'b0;
    chk("R5 forced busy", {15'd0, break_busy}, 16'd1);

    // R9 software clear of a busy break
    wr(2'd0, 8'h00);
    chk("R9 write 0 ends busy", {15'd0, break_busy}, 16'd0);
    rd("R9 active cleared", 2'd0, 8'h00);

    // R9 software cancel of a pending break
    wr(2'd0, 8'h01);
    fetch(16'h1234, 1'b1);
    rd("R9 pending again", 2'd0, 8'h03);
    wr(2'd0, 8'h01);
    rd("R9 cancel pending", 2'd0, 8'h01);
    instr_done = 1'b1; #1;
    chk("R9 no inject after cancel", {15'd0, swi_inject}, 16'd0);
    step(); instr_done = 1'b0;

    // R7 vector for both modes
    for (int m = 0; m < 2; m++) begin
      monitor_mode = 1'(m); #1;
      chk("R7 vector sweep", vec_addr, (m == 1) ? 16'hFEFC : 16'hFFFC);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule